// File: doc/BRIEF.md
# Vectored Interrupt Entry Unit

This unit performs the architectural state change a processor core makes when an external interrupt controller hands it a vectored request. A request names a destination register set, an interrupt level, a non-maskable flag and a handler address. When the request is accepted, the unit rewrites the status register, loads the program counter with the handler address and switches the active register-set selector, all on the same clock edge.

The old status and the interrupted program counter are not kept in a fixed control register. They are stored in the destination shadow register set through a single write port, over the two cycles that follow acceptance. The stored copy of the old status carries a set-switched flag when the destination set differs from the set that was active. When no exception is being handled, the old status is also copied into a saved-status register.

The core writes the status register and the program counter through its own ports. While it does so, the request is held off. The status layout used here is: bit 0 interrupt enable (kept), bit 1 user mode, bit 2 exception-handling flag, bit 3 interrupt-handler flag, bits 9:4 interrupt level, bits 15:10 current register set, bits 21:16 previous register set, bit 22 non-maskable flag, bit 23 register-set interrupt enable, bit 31 set-switched flag. Bits 30:24 are kept as they are.

Top module: `vec_irq_entry`

## Requirements
- R1: After reset: status 0, saved status 0, PC equal to the RESET_PC parameter, active set 0, no shadow write, and req_ready high.
- R2: On acceptance the new status takes the requested set in bits 15:10, the requested level in bits 9:4 and the non-maskable flag in bit 22.
- R3: On acceptance the new status clears bit 23 and bit 1 and sets bit 3. Bits 0, 2, 31 and 30:24 keep their old values.
- R4: If old bit 2 (exception handling) is 0, the new bits 21:16 take the old current set from bits 15:10. If old bit 2 is 1, bits 21:16 keep their value.
- R5: If old bit 2 is 0, the saved-status register takes the old status on acceptance. If old bit 2 is 1, the saved-status register is left unchanged.
- R6: On the edge of acceptance the PC takes the handler address and the active-set output takes the requested set.
- R7: In the cycle after acceptance the shadow port writes set = requested set, select = 30. The data is the old status with bit 31 forced to 1 when the requested set differs from the old bits 15:10, and bit 31 left as it was otherwise.
- R8: In the second cycle after acceptance the shadow port writes set = requested set, select = 29, data = the PC before acceptance. In the third cycle the port is idle.
- R9: req_ready is low while either shadow write is pending and in any cycle where the core writes status or PC. A request held without ready changes nothing.
- R10: A core status write loads status, and its bits 15:10 load the active-set output. A core PC write loads the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_set | input | 6 | Destination register set |
| req_level | input | 6 | Interrupt level |
| req_nmi | input | 1 | Non-maskable request |
| req_handler | input | 32 | Handler address |
| core_st_we | input | 1 | Core write of the status register |
| core_st_data | input | 32 | Status value to write |
| core_pc_we | input | 1 | Core write of the PC |
| core_pc_data | input | 32 | PC value to write |
| status_o | output | 32 | Status register |
| estatus_o | output | 32 | Saved-status register |
| pc_o | output | 32 | Program counter |
| act_set_o | output | 6 | Active register-set selector |
| shd_we_o | output | 1 | Shadow register write enable |
| shd_set_o | output | 6 | Shadow set index of the write |
| shd_sel_o | output | 5 | Register select within the set |
| shd_data_o | output | 32 | Shadow write data |

## Verification
Two functions can fall in the same cycle. An interrupt request can arrive in the same cycle as a core write of the status register. A new request can also stay valid while the two shadow writes of the previous one are still in progress. The bench provokes the first case by driving req_valid together with core_st_we. It then checks that the core value lands in status, that no shadow write starts, and that the request is taken one cycle later against the newly written status. It provokes the second case by holding a different request during both write cycles. It checks that status, PC and the shadow data still reflect only the first request.

// File: rtl/vie_pkg.sv
package vie_pkg;
  localparam int XLEN   = 32;
  localparam int SET_W  = 6;
  localparam int LVL_W  = 6;
  localparam int SEL_W  = 5;

  localparam int PIE_B  = 0;
  localparam int U_B    = 1;
  localparam int EH_B   = 2;
  localparam int IH_B   = 3;
  localparam int IL_LO  = 4;
  localparam int CRS_LO = IL_LO + LVL_W;
  localparam int PRS_LO = CRS_LO + SET_W;
  localparam int NMI_B  = PRS_LO + SET_W;
  localparam int RSIE_B = NMI_B + 1;
  localparam int SRS_B  = XLEN - 1;

  localparam logic [SEL_W-1:0] SEL_SSTATUS = 5'd30;
  localparam logic [SEL_W-1:0] SEL_RETADDR = 5'd29;

  typedef enum logic [1:0] {
    SV_IDLE = 2'd0,
    SV_STAT = 2'd1,
    SV_RET  = 2'd2
  } save_state_e;

  function automatic logic [SET_W-1:0] crs_of(input logic [XLEN-1:0] s);
    return s[CRS_LO +: SET_W];
  endfunction

  function automatic logic [XLEN-1:0] entry_status(
    input logic [XLEN-1:0]  old_s,
    input logic [SET_W-1:0] set_n,
    input logic [LVL_W-1:0] lvl,
    input logic             nmi
  );
    logic [XLEN-1:0] s;
    s = old_s;
    s[CRS_LO +: SET_W] = set_n;
    s[IL_LO  +: LVL_W] = lvl;
    s[NMI_B]  = nmi;
    s[RSIE_B] = 1'b0;
    s[U_B]    = 1'b0;
    s[IH_B]   = 1'b1;
    if (!old_s[EH_B]) s[PRS_LO +: SET_W] = old_s[CRS_LO +: SET_W];
    return s;
  endfunction

  function automatic logic [XLEN-1:0] saved_copy(
    input logic [XLEN-1:0]  old_s,
    input logic [SET_W-1:0] set_n
  );
    logic [XLEN-1:0] s;
    s = old_s;
    if (set_n != old_s[CRS_LO +: SET_W]) s[SRS_B] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/vie_entry_calc.sv
module vie_entry_calc
  import vie_pkg::*;
(
  input  logic [XLEN-1:0]  old_status,
  input  logic [SET_W-1:0] req_set,
  input  logic [LVL_W-1:0] req_level,
  input  logic             req_nmi,
  output logic [XLEN-1:0]  new_status,
  output logic [XLEN-1:0]  save_status,
  output logic             estatus_wr,
  output logic             set_switch
);
  always_comb begin
    new_status  = entry_status(old_status, req_set, req_level, req_nmi);
    save_status = saved_copy(old_status, req_set);
    estatus_wr  = ~old_status[EH_B];
    set_switch  = (req_set != crs_of(old_status));
  end

  // R3
  handler_bit_chk: assert final (new_status[IH_B] && !new_status[U_B] && !new_status[RSIE_B]);
  // R7
  switch_flag_chk: assert final (!set_switch || save_status[SRS_B]);
endmodule

// File: rtl/vie_save_seq.sv
module vie_save_seq
  import vie_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] dst_set,
  input  logic [XLEN-1:0]  old_status,
  input  logic [XLEN-1:0]  old_pc,
  output logic             busy,
  output logic             wr_en,
  output logic [SET_W-1:0] wr_set,
  output logic [SEL_W-1:0] wr_sel,
  output logic [XLEN-1:0]  wr_data
);
  save_state_e       st_q;
  logic [SET_W-1:0]  set_q;
  logic [XLEN-1:0]   stat_q;
  logic [XLEN-1:0]   pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SV_IDLE;
      set_q  <= '0;
      stat_q <= '0;
      pc_q   <= '0;
    end else begin
      unique case (st_q)
        SV_IDLE: if (start) begin
          st_q   <= SV_STAT;
          set_q  <= dst_set;
          stat_q <= old_status;
          pc_q   <= old_pc;
        end
        SV_STAT: st_q <= SV_RET;
        SV_RET:  st_q <= SV_IDLE;
        default: st_q <= SV_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (st_q != SV_IDLE);
    wr_en   = busy;
    wr_set  = set_q;
    wr_sel  = (st_q == SV_RET) ? SEL_RETADDR : SEL_SSTATUS;
    wr_data = (st_q == SV_RET) ? pc_q : stat_q;
  end

  // R8
  ret_follows_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SV_STAT) |=> (wr_en && wr_sel == SEL_RETADDR && $stable(wr_set)));
  // R8
  idle_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SV_RET) |=> !wr_en);
  // R7
  stat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (wr_en && wr_sel == SEL_SSTATUS && wr_set == $past(dst_set)));
endmodule

// File: rtl/vec_irq_entry.sv
module vec_irq_entry
  import vie_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic [LVL_W-1:0] req_level,
  input  logic             req_nmi,
  input  logic [XLEN-1:0]  req_handler,
  input  logic             core_st_we,
  input  logic [XLEN-1:0]  core_st_data,
  input  logic             core_pc_we,
  input  logic [XLEN-1:0]  core_pc_data,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  estatus_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [SET_W-1:0] act_set_o,
  output logic             shd_we_o,
  output logic [SET_W-1:0] shd_set_o,
  output logic [SEL_W-1:0] shd_sel_o,
  output logic [XLEN-1:0]  shd_data_o
);
  logic [XLEN-1:0]  status_q, estatus_q, pc_q;
  logic [SET_W-1:0] act_set_q;
  logic             accept, save_busy;
  logic [XLEN-1:0]  new_status, save_status;
  logic             estatus_wr, set_switch;

  assign req_ready = ~save_busy & ~core_st_we & ~core_pc_we;
  assign accept    = req_valid & req_ready;

  vie_entry_calc u_calc (
    .old_status  (status_q),
    .req_set     (req_set),
    .req_level   (req_level),
    .req_nmi     (req_nmi),
    .new_status  (new_status),
    .save_status (save_status),
    .estatus_wr  (estatus_wr),
    .set_switch  (set_switch)
  );

  vie_save_seq u_save (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .dst_set    (req_set),
    .old_status (save_status),
    .old_pc     (pc_q),
    .busy       (save_busy),
    .wr_en      (shd_we_o),
    .wr_set     (shd_set_o),
    .wr_sel     (shd_sel_o),
    .wr_data    (shd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      estatus_q <= '0;
      pc_q      <= RESET_PC;
      act_set_q <= '0;
    end else if (accept) begin
      status_q  <= new_status;
      act_set_q <= req_set;
      pc_q      <= req_handler;
      if (estatus_wr) estatus_q <= status_q;
    end else begin
      if (core_st_we) begin
        status_q  <= core_st_data;
        act_set_q <= crs_of(core_st_data);
      end
      if (core_pc_we) pc_q <= core_pc_data;
    end
  end

  assign status_o  = status_q;
  assign estatus_o = estatus_q;
  assign pc_o      = pc_q;
  assign act_set_o = act_set_q;

  // R6
  act_set_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_q == status_q[CRS_LO +: SET_W]);
  // R6
  handler_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pc_q == $past(req_handler)));
  // R2
  fields_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (status_q[CRS_LO +: SET_W] == $past(req_set) &&
                status_q[IL_LO +: LVL_W] == $past(req_level) &&
                status_q[NMI_B] == $past(req_nmi)));
  // R5
  estatus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && status_q[EH_B]) |=> $stable(estatus_q));
  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shd_we_o |-> !req_ready);
endmodule

// File: tb/vec_irq_entry_tb.sv
module vec_irq_entry_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [5:0]  req_set = 0;
  logic [5:0]  req_level = 0;
  logic        req_nmi = 0;
  logic [31:0] req_handler = 0;
  logic        core_st_we = 0;
  logic [31:0] core_st_data = 0;
  logic        core_pc_we = 0;
  logic [31:0] core_pc_data = 0;
  logic [31:0] status_o, estatus_o, pc_o, shd_data_o;
  logic [5:0]  act_set_o, shd_set_o;
  logic        shd_we_o;
  logic [4:0]  shd_sel_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_st, m_est, m_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_entry #(.RESET_PC(RST_PC)) u_dut (.*);

  // expected new status, built by masks
  function automatic logic [31:0] want_status(input logic [31:0] o, input logic [5:0] s,
                                              input logic [5:0] l, input logic n);
    logic [31:0] keep;
    logic [31:0] r;
    keep = 32'hFF00_0005 | (o[2] ? 32'h003F_0000 : 32'h0);
    r = (o & keep) | 32'h8 | ({26'd0, l} << 4) | ({26'd0, s} << 10) | ({31'd0, n} << 22);
    if (!o[2]) r = r | ({26'd0, o[15:10]} << 16);
    return r;
  endfunction

  function automatic logic [31:0] want_saved(input logic [31:0] o, input logic [5:0] s);
    return (s == o[15:10]) ? o : (o | 32'h8000_0000);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic st_write(input logic [31:0] d);
    @(negedge clk); core_st_we = 1; core_st_data = d;
    @(negedge clk); core_st_we = 0;
    m_st = d;
    check(status_o == d, "R10 status write", status_o, d);
    check(act_set_o == d[15:10], "R10 act set from write", {26'd0, act_set_o}, {26'd0, d[15:10]});
  endtask

  task automatic pc_write(input logic [31:0] d);
    @(negedge clk); core_pc_we = 1; core_pc_data = d;
    @(negedge clk); core_pc_we = 0;
    m_pc = d;
    check(pc_o == d, "R10 pc write", pc_o, d);
  endtask

  // request; if held_busy, a second request is held during both write cycles
  task automatic irq(input logic [5:0] s, input logic [5:0] l, input logic n,
                     input logic [31:0] h, input bit held_busy);
    logic [31:0] exp_st, exp_sv, exp_est;
    exp_st  = want_status(m_st, s, l, n);
    exp_sv  = want_saved(m_st, s);
    exp_est = m_st[2] ? m_est : m_st;
    @(negedge clk);
    req_valid = 1; req_set = s; req_level = l; req_nmi = n; req_handler = h;
    #1 check(req_ready == 1'b1, "R9 ready when idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (held_busy) begin
      req_set = ~s; req_level = ~l; req_nmi = ~n; req_handler = ~h;
    end else req_valid = 0;
    check(status_o[15:10] == s && status_o[9:4] == l && status_o[22] == n,
          "R2 set/level/nmi", status_o, exp_st);
    check(status_o == exp_st, "R3 R4 full status", status_o, exp_st);
    check(estatus_o == exp_est, "R5 saved status", estatus_o, exp_est);
    check(pc_o == h, "R6 pc", pc_o, h);
    check(act_set_o == s, "R6 act set", {26'd0, act_set_o}, {26'd0, s});
    check(shd_we_o && shd_set_o == s && shd_sel_o == 5'd30, "R7 slot",
          {20'd0, shd_we_o, shd_set_o, shd_sel_o}, {20'd0, 1'b1, s, 5'd30});
    check(shd_data_o == exp_sv, "R7 saved copy", shd_data_o, exp_sv);
    #1 check(req_ready == 1'b0, "R9 busy write1", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check(shd_we_o && shd_set_o == s && shd_sel_o == 5'd29, "R8 slot",
          {20'd0, shd_we_o, shd_set_o, shd_sel_o}, {20'd0, 1'b1, s, 5'd29});
    check(shd_data_o == m_pc, "R8 return pc", shd_data_o, m_pc);
    check(req_ready == 1'b0, "R9 busy write2", {31'd0, req_ready}, 32'd0);
    if (held_busy)
      check(status_o == exp_st && pc_o == h, "R9 held request ignored", status_o, exp_st);
    req_valid = 0;
    @(negedge clk);
    check(!shd_we_o && req_ready, "R8 idle after", {30'd0, shd_we_o, req_ready}, 32'd1);
    m_st = exp_st; m_est = exp_est; m_pc = h;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_st = 0; m_est = 0; m_pc = RST_PC;
    // R1
    check(status_o == 0 && estatus_o == 0, "R1 status reset", status_o, 0);
    check(pc_o == RST_PC, "R1 pc reset", pc_o, RST_PC);
    check(act_set_o == 0 && !shd_we_o && req_ready, "R1 port reset",
          {24'd0, act_set_o, shd_we_o, req_ready}, 32'd1);

    // directed: EH clear, set switch
    st_write(32'h7F80_0C13);
    irq(6'd5, 6'd9, 1'b0, 32'h0000_4000, 1'b0);
    // directed: same set, no switch flag, EH set keeps PRS and saved status
    st_write(32'h0055_1407 | 32'h0080_0000);
    irq(6'd5, 6'd63, 1'b1, 32'h0000_8000, 1'b0);
    // directed: request held during busy (R9)
    irq(6'd12, 6'd3, 1'b0, 32'h0001_0000, 1'b1);

    // collision: request with core status write (R9)
    @(negedge clk);
    req_valid = 1; req_set = 6'd7; req_level = 6'd2; req_nmi = 0; req_handler = 32'h2222_0000;
    core_st_we = 1; core_st_data = 32'h0000_2C02;
    #1 check(req_ready == 1'b0, "R9 blocked by status write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    core_st_we = 0; req_valid = 0;
    m_st = 32'h0000_2C02;
    check(status_o == m_st, "R9 core write wins", status_o, m_st);
    check(!shd_we_o, "R9 no shadow write", {31'd0, shd_we_o}, 32'd0);
    irq(6'd7, 6'd2, 1'b0, 32'h2222_0000, 1'b0);

    // collision with pc write (R9)
    @(negedge clk);
    req_valid = 1; core_pc_we = 1; core_pc_data = 32'h0BAD_0000;
    #1 check(req_ready == 1'b0, "R9 blocked by pc write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    core_pc_we = 0; req_valid = 0; m_pc = 32'h0BAD_0000;
    check(pc_o == m_pc && status_o == m_st, "R9 pc write wins", pc_o, m_pc);

    // random
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 1) == 1) st_write($urandom());
      if ($urandom_range(0, 2) == 0) pc_write($urandom());
      irq(6'($urandom()), 6'($urandom()), 1'($urandom()), $urandom(),
          $urandom_range(0, 4) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule